// File: doc/BRIEF.md
# Merging Write Buffer with Read Bypass

This block sits between a write-through cache and the memory port. Each processor store hands over a block address, a word index inside the block, one data word and its byte enables. The store is absorbed into the buffer in a single cycle, and the processor only waits when every slot is taken. If a slot for the same block is still pending and open, the store is folded into that slot. Newer bytes overwrite older ones and no slot is consumed. Slots leave for memory in arrival order, one per accepted handshake on the drain port.

A read miss gets priority over the drain. While a read request is raised, the buffer stops offering slots to memory and searches every pending slot for the read's block. It reports whether any slot conflicts. It also returns a word built from two sources: bytes that pending slots hold come from the buffer, with the newest slot winning, and all other bytes come from the word that memory returned for the read. The slot currently offered to memory is closed. A later store to that block opens a fresh slot, so the data in flight never changes under the memory port.

Top module: `merging_wbuf`

## Requirements
- R1: After reset the buffer reports empty (`bufEmpty`=1), not full (`bufFull`=0), and offers nothing on the drain port (`drnValid`=0).
- R2: A store presented with `wrValid`=1 while `bufFull`=0 is accepted on that clock edge and the processor does not wait; from the next cycle the buffer is not empty.
- R3: A store whose block matches an open pending slot updates that slot in place. Its enabled bytes replace the older bytes, the slot's byte-valid bits become the union, and no extra slot is used.
- R4: The drain port presents the oldest slot. `drnData` packs word w at bits [w*32 +: 32] and `drnBe` packs word w's byte enables at bits [w*4 +: 4]. A slot is removed on a cycle with `drnValid`=1 and `drnAck`=1, and its contents do not change while it waits for acceptance.
- R5: While `rdReq`=1, `drnValid` stays 0, so the read reaches memory ahead of all pending stores.
- R6: `rdConflict` is 1 exactly when some pending slot holds the block `rdBlk`.
- R7: `rdMerged` byte b comes from the newest pending slot of block `rdBlk` that has byte b of word `rdWord` valid. If no such slot has that byte valid, byte b comes from `rdMemData`. With no conflict, `rdMerged` equals `rdMemData`.
- R8: Once a slot has been offered on the drain port it takes no more merges. A store to its block allocates a new slot, and the two slots drain in order.
- R9: With all 4 slots in use, `bufFull`=1, and a store presented then is not accepted and leaves no trace in the buffer.
- R10: After every slot has been accepted by the drain port, `bufEmpty` returns to 1 and `drnValid` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Processor store request |
| wrBlk | input | 28 | Block address of the store |
| wrWord | input | 2 | Word index inside the block |
| wrData | input | 32 | Store data word |
| wrBe | input | 4 | Byte enables of the store |
| bufFull | output | 1 | All slots in use; the processor must hold its store |
| bufEmpty | output | 1 | No pending slot |
| rdReq | input | 1 | Read miss in progress; lookup active, drain held off |
| rdBlk | input | 28 | Block address of the read |
| rdWord | input | 2 | Word index of the read |
| rdMemData | input | 32 | Word returned by memory for the read |
| rdConflict | output | 1 | A pending slot holds the read's block |
| rdMerged | output | 32 | Read word with pending bytes forwarded |
| drnValid | output | 1 | Oldest slot offered to memory |
| drnAck | input | 1 | Memory accepts the offered slot |
| drnBlk | output | 28 | Block address of the offered slot |
| drnData | output | 128 | Data of the offered slot, word 0 in the low bits |
| drnBe | output | 16 | Byte-valid bits of the offered slot |

## Verification
Corrupt slot state shows up at the ports in one of two ways. A bad merge or a bad byte-valid bit changes `rdMerged` in the same cycle as the next read of that block. It also changes `drnData`/`drnBe` when that slot reaches the head. A bad pointer or occupancy count appears as a wrong block order on the drain port, a stray extra drain, or `bufEmpty`/`bufFull` switching one handshake early or late. The tests therefore drain every slot they create and compare each drained slot in full against the expected slot.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  // widest slot index the strobe struct can carry (up to 16 slots)
  localparam int WB_IDX_MAX_W = 4;

  typedef struct packed {
    logic                    allocEn;
    logic                    mergeEn;
    logic [WB_IDX_MAX_W-1:0] allocIdx;
    logic [WB_IDX_MAX_W-1:0] mergeIdx;
    logic [WB_IDX_MAX_W-1:0] headIdx;
  } wbufStrb_t;
endpackage

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrValid,
  input  logic         rdReq,
  input  logic         drnAck,
  input  logic [N-1:0] blkHitWr,
  output logic [N-1:0] validVec,
  output wbufStrb_t    strb,
  output logic         bufEmpty,
  output logic         bufFull,
  output logic         drnValid
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int CNT_W = $clog2(N + 1);

  logic [IDX_W-1:0] headPtr, tailPtr, hitIdx;
  logic [CNT_W-1:0] count;
  logic             headClosed, headLock, pop, accept, anyHit;
  logic [N-1:0]     openHit;

  assign bufFull  = (count == CNT_W'(N));
  assign bufEmpty = (count == '0);
  assign drnValid = !bufEmpty && !rdReq;
  assign pop      = drnValid && drnAck;
  // head stays closed once it has been offered to memory
  assign headLock = headClosed || drnValid;
  assign accept   = wrValid && !bufFull;

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < N; i++) begin
      openHit[i] = validVec[i] && blkHitWr[i] &&
                   !((IDX_W'(i) == headPtr) && headLock);
      if (openHit[i]) hitIdx = IDX_W'(i);
    end
  end
  assign anyHit = |openHit;

  always_comb begin
    strb          = '0;
    strb.allocEn  = accept && !anyHit;
    strb.mergeEn  = accept && anyHit;
    strb.allocIdx = WB_IDX_MAX_W'(tailPtr);
    strb.mergeIdx = WB_IDX_MAX_W'(hitIdx);
    strb.headIdx  = WB_IDX_MAX_W'(headPtr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec   <= '0;
      headPtr    <= '0;
      tailPtr    <= '0;
      count      <= '0;
      headClosed <= 1'b0;
    end else begin
      if (strb.allocEn) begin
        validVec[tailPtr] <= 1'b1;
        tailPtr <= (tailPtr == IDX_W'(N - 1)) ? '0 : tailPtr + 1'b1;
      end
      if (pop) begin
        validVec[headPtr] <= 1'b0;
        headPtr <= (headPtr == IDX_W'(N - 1)) ? '0 : headPtr + 1'b1;
      end
      case ({strb.allocEn, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (pop)           headClosed <= 1'b0;
      else if (drnValid) headClosed <= 1'b1;
    end
  end
endmodule

// File: rtl/wbuf_data.sv
module wbuf_data
  import wbuf_pkg::*;
#(
  parameter int N      = 4,
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int BLK_W  = 28
) (
  input  logic                      clk,
  input  wbufStrb_t                 strb,
  input  logic [N-1:0]              validVec,
  input  logic [BLK_W-1:0]          wrBlk,
  input  logic [$clog2(WORDS)-1:0]  wrWord,
  input  logic [WORD_W-1:0]         wrData,
  input  logic [WORD_W/8-1:0]       wrBe,
  input  logic [BLK_W-1:0]          rdBlk,
  input  logic [$clog2(WORDS)-1:0]  rdWord,
  input  logic [WORD_W-1:0]         rdMemData,
  output logic [N-1:0]              blkHitWr,
  output logic                      rdConflict,
  output logic [WORD_W-1:0]         rdMerged,
  output logic [BLK_W-1:0]          drnBlk,
  output logic [WORDS*WORD_W-1:0]   drnData,
  output logic [WORDS*WORD_W/8-1:0] drnBe
);
  localparam int BYTES = WORD_W / 8;

  logic [BLK_W-1:0]                  blkQ  [N];
  logic [WORDS-1:0][BYTES-1:0][7:0]  dataQ [N];
  logic [WORDS-1:0][BYTES-1:0]       beQ   [N];

  function automatic int wrapIdx(input int h, input int k);
    int s;
    s = h + k;
    if (s >= N) s = s - N;
    return s;
  endfunction

  // slot storage: fresh slot on allocation, byte-wise update on merge
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (strb.allocEn && strb.allocIdx == WB_IDX_MAX_W'(i)) begin
        blkQ[i] <= wrBlk;
        for (int w = 0; w < WORDS; w++) begin
          for (int b = 0; b < BYTES; b++) begin
            beQ[i][w][b]   <= (w == int'(wrWord)) && wrBe[b];
            dataQ[i][w][b] <= ((w == int'(wrWord)) && wrBe[b]) ?
                              wrData[b*8 +: 8] : 8'h00;
          end
        end
      end else if (strb.mergeEn && strb.mergeIdx == WB_IDX_MAX_W'(i)) begin
        for (int b = 0; b < BYTES; b++) begin
          if (wrBe[b]) begin
            beQ[i][wrWord][b]   <= 1'b1;
            dataQ[i][wrWord][b] <= wrData[b*8 +: 8];
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) blkHitWr[i] = (blkQ[i] == wrBlk);
  end

  // read lookup: walk oldest to newest so newer slots override bytes
  always_comb begin
    rdMerged   = rdMemData;
    rdConflict = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (validVec[wrapIdx(int'(strb.headIdx), k)] &&
          blkQ[wrapIdx(int'(strb.headIdx), k)] == rdBlk) begin
        rdConflict = 1'b1;
        for (int b = 0; b < BYTES; b++) begin
          if (beQ[wrapIdx(int'(strb.headIdx), k)][rdWord][b])
            rdMerged[b*8 +: 8] = dataQ[wrapIdx(int'(strb.headIdx), k)][rdWord][b];
        end
      end
    end
  end

  assign drnBlk  = blkQ[strb.headIdx];
  assign drnData = dataQ[strb.headIdx];
  assign drnBe   = beQ[strb.headIdx];
endmodule

// File: rtl/merging_wbuf.sv
module merging_wbuf
  import wbuf_pkg::*;
#(
  parameter int N      = 4,
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int BLK_W  = 28
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrValid,
  input  logic [BLK_W-1:0]          wrBlk,
  input  logic [$clog2(WORDS)-1:0]  wrWord,
  input  logic [WORD_W-1:0]         wrData,
  input  logic [WORD_W/8-1:0]       wrBe,
  output logic                      bufFull,
  output logic                      bufEmpty,
  input  logic                      rdReq,
  input  logic [BLK_W-1:0]          rdBlk,
  input  logic [$clog2(WORDS)-1:0]  rdWord,
  input  logic [WORD_W-1:0]         rdMemData,
  output logic                      rdConflict,
  output logic [WORD_W-1:0]         rdMerged,
  output logic                      drnValid,
  input  logic                      drnAck,
  output logic [BLK_W-1:0]          drnBlk,
  output logic [WORDS*WORD_W-1:0]   drnData,
  output logic [WORDS*WORD_W/8-1:0] drnBe
);
  wbufStrb_t    strb;
  logic [N-1:0] validVec, blkHitWr;

  wbuf_ctrl #(.N(N)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdReq(rdReq),
    .drnAck(drnAck), .blkHitWr(blkHitWr), .validVec(validVec),
    .strb(strb), .bufEmpty(bufEmpty), .bufFull(bufFull),
    .drnValid(drnValid)
  );

  wbuf_data #(.N(N), .WORDS(WORDS), .WORD_W(WORD_W), .BLK_W(BLK_W)) data_i (
    .clk(clk), .strb(strb), .validVec(validVec), .wrBlk(wrBlk),
    .wrWord(wrWord), .wrData(wrData), .wrBe(wrBe), .rdBlk(rdBlk),
    .rdWord(rdWord), .rdMemData(rdMemData), .blkHitWr(blkHitWr),
    .rdConflict(rdConflict), .rdMerged(rdMerged), .drnBlk(drnBlk),
    .drnData(drnData), .drnBe(drnBe)
  );
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  parameter int BLK_W  = 28
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      wrValid,
  input logic                      bufFull,
  input logic                      bufEmpty,
  input logic                      rdReq,
  input logic [WORD_W-1:0]         rdMemData,
  input logic                      rdConflict,
  input logic [WORD_W-1:0]         rdMerged,
  input logic                      drnValid,
  input logic                      drnAck,
  input logic [BLK_W-1:0]          drnBlk,
  input logic [WORDS*WORD_W-1:0]   drnData,
  input logic [WORDS*WORD_W/8-1:0] drnBe
);
  // R2
  accept_when_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufEmpty && wrValid) |=> !bufEmpty);

  // R4
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (drnValid && !drnAck) |=> ($stable(drnBlk) && $stable(drnData) && $stable(drnBe)));

  // R5
  read_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |-> !drnValid);

  // R7
  no_conflict_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdConflict |-> (rdMerged == rdMemData));

  // R9
  full_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufFull && !(drnValid && drnAck)) |=> bufFull);

  // R10
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufEmpty |-> !drnValid);
endmodule

bind merging_wbuf wbuf_chk #(.WORDS(WORDS), .WORD_W(WORD_W), .BLK_W(BLK_W)) chk_i (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .bufFull(bufFull),
  .bufEmpty(bufEmpty), .rdReq(rdReq), .rdMemData(rdMemData),
  .rdConflict(rdConflict), .rdMerged(rdMerged), .drnValid(drnValid),
  .drnAck(drnAck), .drnBlk(drnBlk), .drnData(drnData), .drnBe(drnBe)
);

// File: tb/merging_wbuf_tb_top.sv
`timescale 1ns/1ps
module merging_wbuf_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrValid = 1'b0;
  logic [27:0]  wrBlk = '0;
  logic [1:0]   wrWord = '0;
  logic [31:0]  wrData = '0;
  logic [3:0]   wrBe = '0;
  logic         bufFull, bufEmpty;
  logic         rdReq = 1'b0;
  logic [27:0]  rdBlk = '0;
  logic [1:0]   rdWord = '0;
  logic [31:0]  rdMemData = '0;
  logic         rdConflict;
  logic [31:0]  rdMerged;
  logic         drnValid;
  logic         drnAck = 1'b0;
  logic [27:0]  drnBlk;
  logic [127:0] drnData;
  logic [15:0]  drnBe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  merging_wbuf dut_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrBlk(wrBlk),
    .wrWord(wrWord), .wrData(wrData), .wrBe(wrBe), .bufFull(bufFull),
    .bufEmpty(bufEmpty), .rdReq(rdReq), .rdBlk(rdBlk), .rdWord(rdWord),
    .rdMemData(rdMemData), .rdConflict(rdConflict), .rdMerged(rdMerged),
    .drnValid(drnValid), .drnAck(drnAck), .drnBlk(drnBlk),
    .drnData(drnData), .drnBe(drnBe)
  );

  task automatic chkEq(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [27:0] b, input logic [1:0] w,
                         input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wrValid = 1'b1; wrBlk = b; wrWord = w; wrData = d; wrBe = be;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic doRead(input string req, input logic [27:0] b, input logic [1:0] w,
                        input logic [31:0] mem, input logic expConf,
                        input logic [31:0] expData);
    @(negedge clk);
    rdReq = 1'b1; rdBlk = b; rdWord = w; rdMemData = mem;
    #1;
    chkEq({req, " conflict"}, 128'(rdConflict), 128'(expConf));
    chkEq({req, " merged"}, 128'(rdMerged), 128'(expData));
    chkEq("R5 drain held during read", 128'(drnValid), 128'(0));
  endtask

  task automatic doDrain(input string req, input logic [27:0] b,
                         input logic [127:0] d, input logic [15:0] be);
    @(negedge clk);
    drnAck = 1'b1;
    #1;
    chkEq({req, " valid"}, 128'(drnValid), 128'(1));
    chkEq({req, " block"}, 128'(drnBlk), 128'(b));
    chkEq({req, " data"}, drnData, d);
    chkEq({req, " enables"}, 128'(drnBe), 128'(be));
    @(negedge clk);
    drnAck = 1'b0;
  endtask

  task automatic testReset();
    #1;
    chkEq("R1 empty", 128'(bufEmpty), 128'(1));
    chkEq("R1 full", 128'(bufFull), 128'(0));
    chkEq("R1 drain idle", 128'(drnValid), 128'(0));
  endtask

  task automatic testMerge();
    @(negedge clk);
    rdReq = 1'b1; rdBlk = 28'h0000077;
    doWrite(28'h10, 2'd1, 32'h11223344, 4'hF);
    #1 chkEq("R2 not empty after store", 128'(bufEmpty), 128'(0));
    doWrite(28'h10, 2'd1, 32'hAABBCCDD, 4'h3);
    doWrite(28'h10, 2'd3, 32'h99000000, 4'h8);
    doRead("R7 merged word1", 28'h10, 2'd1, 32'h55555555, 1'b1, 32'h1122CCDD);
    doRead("R7 merged word3", 28'h10, 2'd3, 32'h00123456, 1'b1, 32'h99123456);
    doRead("R6 conflict no bytes", 28'h10, 2'd0, 32'hDEADBEEF, 1'b1, 32'hDEADBEEF);
    @(negedge clk);
    rdReq = 1'b0;
    doDrain("R3 merged slot", 28'h10,
            {32'h99000000, 32'h0, 32'h1122CCDD, 32'h0}, 16'h80F0);
    #1 chkEq("R3 single slot used / R10 empty", 128'(bufEmpty), 128'(1));
    chkEq("R10 drain idle", 128'(drnValid), 128'(0));
  endtask

  task automatic testFill();
    for (int i = 1; i <= 4; i++)
      doWrite(28'(i), 2'd0, 32'(i * 32'h01010101), 4'hF);
    #1 chkEq("R9 full after 4 slots", 128'(bufFull), 128'(1));
    doWrite(28'h5, 2'd0, 32'hFFFFFFFF, 4'hF);
    #1 chkEq("R9 still full", 128'(bufFull), 128'(1));
    for (int i = 1; i <= 4; i++)
      doDrain("R4 oldest first", 28'(i), {96'h0, 32'(i * 32'h01010101)}, 16'h000F);
    #1 chkEq("R9 dropped store left no slot", 128'(bufEmpty), 128'(1));
    chkEq("R10 drain idle after fill", 128'(drnValid), 128'(0));
  endtask

  task automatic testClosedHead();
    doWrite(28'h20, 2'd0, 32'h12345678, 4'hF);
    // the slot is now offered to memory, so it is closed for merging
    doWrite(28'h20, 2'd0, 32'h000000BB, 4'h1);
    doRead("R7 newest slot wins", 28'h20, 2'd0, 32'h00000000, 1'b1, 32'h123456BB);
    doRead("R6 no conflict", 28'h77, 2'd2, 32'hCAFEF00D, 1'b0, 32'hCAFEF00D);
    @(negedge clk);
    rdReq = 1'b0;
    doDrain("R8 first slot unchanged", 28'h20, {96'h0, 32'h12345678}, 16'h000F);
    doDrain("R8 second slot", 28'h20, {96'h0, 32'h000000BB}, 16'h0001);
    #1 chkEq("R10 empty at end", 128'(bufEmpty), 128'(1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    testMerge();
    testFill();
    testClosedHead();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule